// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates and vectors interrupts for a small 8-bit processor. It holds one request flag for each of twelve maskable sources. Four of them are external pins with a selectable active edge. Five are timer underflow strobes. The rest are a serial-transfer-done strobe, a key-input wake-up and an A-D completion strobe. Beside these it tracks a reset entry, pending from reset until it is served, and a non-maskable software break. Each cycle it combines the request flags, the enable flags and a global disable flag, and it presents the winning source together with the 16-bit address of its vector low byte. The high byte sits at the next address.

The processor takes the presented source with an accept strobe. In the same clock the block sets the global disable flag and drops the pending state of the accepted source. Software reaches the enable flags, the request flags, the edge polarities and the disable flag through a small register port. Request flags can be cleared from that port but never set. Stacking of the program counter and status, and the processor itself, lie outside this block.

Top module: `irq_vector_unit`

## Requirements
- R1: A maskable source is presented only when its request flag is 1, its enable flag is 1 and the disable flag is 0. The presented outputs follow a change of these flags one clock after the change.
- R2: The register map is: address 0 holds the enables (bit i is source i), address 1 holds the requests, address 2 holds the polarities (bits 3..0 for the four external pins, 1 = falling edge) and address 3 bit 0 holds the disable flag. Enables, polarities and the flag take the written value. A write to address 1 clears each request bit written 0 and leaves each bit written 1 unchanged. Read data is registered: it appears one clock after the address and shows the register contents from before that clock.
- R3: The priority is fixed, from highest to lowest: reset (code 0), then maskable sources in bit order 0..11, then break (code 13). The maskable bits are 0 pin A, 1 pin B, 2 timer X, 3 timer Y, 4 timer 1, 5 timer 3, 6 pin C, 7 pin D, 8 timer 2, 9 serial, 10 key and 11 A-D. The code of maskable bit i is i+1.
- R4: The vector low-byte address for codes 0 to 13 is, in order: FFFC, FFFA, FFF8, FFF2, FFF0, FFEE, FFEC, FFEA, FFE8, FFE6, FFE2, FFE0, FFDE, FFDC.
- R5: An accept while irq_valid is high sets the disable flag and clears the presented source's pending state. irq_valid is low in the following cycle.
- R6: A break strobe is latched and is presented even while the disable flag is 1. It stays pending until it is accepted.
- R7: An external pin sets its request flag on its active edge: rising when its polarity bit is 0, falling when it is 1. The flag is readable 3 clocks after the pin changes.
- R8: Changing a polarity bit sets that pin's request flag when the pin level XOR the new polarity goes from 0 to 1.
- R9: The key request is set on a falling transition of the AND over key pins in input mode. Pins in output mode count as high.
- R10: An A-D completion strobe sets bit 11 only while adc_sel is 1.
- R11: When a hardware set and a software clear hit the same request bit in the same clock, the bit ends up 1.
- R12: After reset the enables and requests are 0, the disable flag is 1, and the reset entry (code 0, FFFC) is presented one clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 4 | External pins A..D (asynchronous) |
| timer_uf | input | 5 | Underflow strobes: X, Y, 1, 3, 2 |
| sio_done | input | 1 | Serial transfer completion strobe |
| key_pin | input | KEY_W | Key port levels (asynchronous) |
| key_in_mode | input | KEY_W | 1 = key pin is in input mode |
| adc_done | input | 1 | A-D completion strobe |
| adc_sel | input | 1 | A-D source owns its shared vector |
| brk_req | input | 1 | Software break strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Registered read data |
| irq_ack | input | 1 | Processor accepts the presented source |
| irq_valid | output | 1 | A source is presented |
| irq_code | output | 4 | Presented source code |
| irq_vec | output | 16 | Vector low-byte address |
| iflag | output | 1 | Global disable flag |

## Verification
A wrong request or enable bit shows up at the ports within one clock. It appears either as a wrong code and vector on the presented outputs or, with the next read, on reg_rdata. A stale pending state after an accept shows up as the same source being presented again two clocks after the accept. A slip in the edge pipeline shifts the request one clock off the 3-clock latency. Each of these is caught by a cycle-by-cycle comparison of every output against a behavioural model.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 12;
  localparam int NEXT = 4;
  localparam int NTMR = 5;
  typedef logic [3:0] code_t;
  localparam code_t CODE_RST = 4'd0;
  localparam code_t CODE_BRK = 4'd13;
  typedef enum logic [1:0] {RA_EN = 2'd0, RA_REQ = 2'd1, RA_POL = 2'd2, RA_IFLAG = 2'd3} reg_addr_e;

  function automatic logic [15:0] vec_of(input code_t c);
    case (c)
      4'd0:    vec_of = 16'hFFFC;
      4'd1:    vec_of = 16'hFFFA;
      4'd2:    vec_of = 16'hFFF8;
      4'd3:    vec_of = 16'hFFF2;
      4'd4:    vec_of = 16'hFFF0;
      4'd5:    vec_of = 16'hFFEE;
      4'd6:    vec_of = 16'hFFEC;
      4'd7:    vec_of = 16'hFFEA;
      4'd8:    vec_of = 16'hFFE8;
      4'd9:    vec_of = 16'hFFE6;
      4'd10:   vec_of = 16'hFFE2;
      4'd11:   vec_of = 16'hFFE0;
      4'd12:   vec_of = 16'hFFDE;
      default: vec_of = 16'hFFDC;
    endcase
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/irq_ext_edge.sv
module irq_ext_edge #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  input  logic [N-1:0] pol,
  output logic [N-1:0] ev
);
  logic [N-1:0] pin_s, lvl, lvl_q;

  irq_sync #(.W(N), .STAGES(STAGES)) u_sync (.clk(clk), .rst(rst), .d(pin), .q(pin_s));

  // active level: a polarity flip alone can produce a 0->1 step here
  assign lvl = pin_s ^ pol;
  assign ev  = lvl & ~lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end
endmodule

// File: rtl/irq_key_fall.sv
module irq_key_fall #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin,
  input  logic [W-1:0] in_mode,
  output logic         fall
);
  logic [W-1:0] pin_s;
  logic         all_hi, all_hi_q;

  irq_sync #(.W(W), .STAGES(STAGES)) u_sync (.clk(clk), .rst(rst), .d(pin), .q(pin_s));

  assign all_hi = &(pin_s | ~in_mode);
  assign fall   = all_hi_q & ~all_hi;

  always_ff @(posedge clk) begin
    if (rst) all_hi_q <= 1'b0;
    else     all_hi_q <= all_hi;
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
(
  input  logic            rst_pend,
  input  logic            brk_pend,
  input  logic            iflag,
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] en,
  output logic            found,
  output code_t           code
);
  logic [NSRC-1:0] live;

  always_comb begin
    live  = req & en & {NSRC{~iflag}};
    found = 1'b0;
    code  = CODE_RST;
    if (rst_pend) begin
      found = 1'b1;
    end else if (|live) begin
      found = 1'b1;
      for (int i = NSRC - 1; i >= 0; i--)
        if (live[i]) code = code_t'(i + 1);
    end else if (brk_pend) begin
      found = 1'b1;
      code  = CODE_BRK;
    end
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_pkg::*;
#(
  parameter int KEY_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NEXT-1:0]  ext_pin,
  input  logic [NTMR-1:0]  timer_uf,
  input  logic             sio_done,
  input  logic [KEY_W-1:0] key_pin,
  input  logic [KEY_W-1:0] key_in_mode,
  input  logic             adc_done,
  input  logic             adc_sel,
  input  logic             brk_req,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [NSRC-1:0]  reg_wdata,
  output logic [NSRC-1:0]  reg_rdata,
  input  logic             irq_ack,
  output logic             irq_valid,
  output logic [3:0]       irq_code,
  output logic [15:0]      irq_vec,
  output logic             iflag
);
  localparam int PAD = NSRC - NEXT;

  logic [NSRC-1:0] en_q, req_q, req_d, hw_set, acc_clr;
  logic [NEXT-1:0] pol_q, ext_ev;
  logic            iflag_q, rst_pend_q, brk_pend_q, key_ev, accept, found;
  logic            wr_en, wr_req, wr_pol, wr_if;
  code_t           sel_code;
  reg_addr_e       ra;

  irq_ext_edge #(.N(NEXT), .STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst(rst), .pin(ext_pin), .pol(pol_q), .ev(ext_ev));

  irq_key_fall #(.W(KEY_W), .STAGES(SYNC_STAGES)) u_key (
    .clk(clk), .rst(rst), .pin(key_pin), .in_mode(key_in_mode), .fall(key_ev));

  irq_prio_sel u_sel (
    .rst_pend(rst_pend_q), .brk_pend(brk_pend_q), .iflag(iflag_q),
    .req(req_q), .en(en_q), .found(found), .code(sel_code));

  assign ra     = reg_addr_e'(reg_addr);
  assign wr_en  = reg_we && (ra == RA_EN);
  assign wr_req = reg_we && (ra == RA_REQ);
  assign wr_pol = reg_we && (ra == RA_POL);
  assign wr_if  = reg_we && (ra == RA_IFLAG);
  assign accept = irq_ack && irq_valid;
  assign iflag  = iflag_q;

  always_comb begin
    hw_set     = '0;
    hw_set[0]  = ext_ev[0];
    hw_set[1]  = ext_ev[1];
    hw_set[2]  = timer_uf[0];
    hw_set[3]  = timer_uf[1];
    hw_set[4]  = timer_uf[2];
    hw_set[5]  = timer_uf[3];
    hw_set[6]  = ext_ev[2];
    hw_set[7]  = ext_ev[3];
    hw_set[8]  = timer_uf[4];
    hw_set[9]  = sio_done;
    hw_set[10] = key_ev;
    hw_set[11] = adc_done & adc_sel;
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      acc_clr[i] = accept && (irq_code == code_t'(i + 1));
    req_d = req_q & ~acc_clr;
    if (wr_req) req_d = req_d & reg_wdata;
    // hardware set applied last so an event is never lost
    req_d = req_d | hw_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= '0;
      req_q      <= '0;
      pol_q      <= '0;
      iflag_q    <= 1'b1;
      rst_pend_q <= 1'b1;
      brk_pend_q <= 1'b0;
      irq_valid  <= 1'b0;
      irq_code   <= '0;
      irq_vec    <= '0;
      reg_rdata  <= '0;
    end else begin
      req_q <= req_d;
      if (wr_en)  en_q  <= reg_wdata;
      if (wr_pol) pol_q <= reg_wdata[NEXT-1:0];
      if (accept)     iflag_q <= 1'b1;
      else if (wr_if) iflag_q <= reg_wdata[0];
      if (accept && irq_code == CODE_RST) rst_pend_q <= 1'b0;
      if (brk_req)                             brk_pend_q <= 1'b1;
      else if (accept && irq_code == CODE_BRK) brk_pend_q <= 1'b0;
      irq_valid <= found && !accept;
      irq_code  <= sel_code;
      irq_vec   <= vec_of(sel_code);
      case (ra)
        RA_EN:   reg_rdata <= en_q;
        RA_REQ:  reg_rdata <= req_q;
        RA_POL:  reg_rdata <= {{PAD{1'b0}}, pol_q};
        default: reg_rdata <= {{(NSRC-1){1'b0}}, iflag_q};
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        irq_ack,
  input logic        irq_valid,
  input logic [3:0]  irq_code,
  input logic [15:0] irq_vec,
  input logic        iflag,
  input logic [11:0] req_q,
  input logic [11:0] hw_set,
  input logic        brk_pend
);
  p_gate_by_flag_r1: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_code >= 4'd1 && irq_code <= 4'd12) |-> $past(!iflag));

  p_no_sw_set_r2: assert property (@(posedge clk) disable iff (rst)
    (req_q & ~$past(req_q) & ~$past(hw_set)) == 12'd0);

  p_vec_shape_r4: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_vec[15:8] == 8'hFF && !irq_vec[0]));

  p_accept_masks_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_valid) |=> iflag);

  p_accept_drops_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_valid) |=> !irq_valid);

  p_brk_held_r6: assert property (@(posedge clk) disable iff (rst)
    (brk_pend && !(irq_ack && irq_valid)) |=> brk_pend);

  p_hw_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (hw_set != 12'd0) |=> ((req_q & $past(hw_set)) == $past(hw_set)));

  p_reset_entry_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |=> (irq_valid && irq_code == 4'd0));
endmodule

bind irq_vector_unit irq_vector_unit_chk u_chk (
  .clk(clk), .rst(rst), .irq_ack(irq_ack), .irq_valid(irq_valid),
  .irq_code(irq_code), .irq_vec(irq_vec), .iflag(iflag),
  .req_q(req_q), .hw_set(hw_set), .brk_pend(brk_pend_q));

// File: tb/tb_irq_vector_unit.sv
`timescale 1ns/1ps
module tb_irq_vector_unit;
  localparam int KW = 8;

  logic clk = 0, rst = 1;
  logic [3:0]  ext_pin = 0;
  logic [4:0]  timer_uf = 0;
  logic        sio_done = 0, adc_done = 0, adc_sel = 0, brk_req = 0;
  logic [KW-1:0] key_pin = '1, key_in_mode = 8'h0F;
  logic        reg_we = 0, irq_ack = 0;
  logic [1:0]  reg_addr = 0;
  logic [11:0] reg_wdata = 0;
  logic [11:0] reg_rdata;
  logic        irq_valid, iflag;
  logic [3:0]  irq_code;
  logic [15:0] irq_vec;

  int checks = 0, errors = 0, cyc = 0;

  irq_vector_unit #(.KEY_W(KW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .timer_uf(timer_uf), .sio_done(sio_done),
    .key_pin(key_pin), .key_in_mode(key_in_mode), .adc_done(adc_done), .adc_sel(adc_sel),
    .brk_req(brk_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_code(irq_code),
    .irq_vec(irq_vec), .iflag(iflag));

  always #2 clk = ~clk;

  function automatic logic [15:0] exp_vec(input int c);
    case (c)
      0: return 16'hFFFC;  1: return 16'hFFFA;  2: return 16'hFFF8;  3: return 16'hFFF2;
      4: return 16'hFFF0;  5: return 16'hFFEE;  6: return 16'hFFEC;  7: return 16'hFFEA;
      8: return 16'hFFE8;  9: return 16'hFFE6; 10: return 16'hFFE2; 11: return 16'hFFE0;
      12: return 16'hFFDE; default: return 16'hFFDC;
    endcase
  endfunction

  // behavioural reference model
  logic [11:0] m_en, m_req, m_rd, hs;
  logic [3:0]  m_pol, e1, e2, e_prev, act;
  logic [KW-1:0] k1, k2;
  logic        k_prev, kand, m_if, m_rp, m_bp, m_valid, acc;
  int          m_code, pick;
  logic [15:0] m_vec;
  bit          started = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_en = 0; m_req = 0; m_pol = 0; m_if = 1; m_rp = 1; m_bp = 0;
      e1 = 0; e2 = 0; e_prev = 0; k1 = 0; k2 = 0; k_prev = 0;
      m_valid = 0; m_code = 0; m_vec = 0; m_rd = 0; started = 1;
    end else begin
      act = e2 ^ m_pol;
      kand = &(k2 | ~key_in_mode);
      hs = 0;
      hs[0] = act[0] & ~e_prev[0]; hs[1] = act[1] & ~e_prev[1];
      hs[6] = act[2] & ~e_prev[2]; hs[7] = act[3] & ~e_prev[3];
      hs[2] = timer_uf[0]; hs[3] = timer_uf[1]; hs[4] = timer_uf[2];
      hs[5] = timer_uf[3]; hs[8] = timer_uf[4]; hs[9] = sio_done;
      hs[10] = k_prev & ~kand; hs[11] = adc_done & adc_sel;
      pick = -1;
      if (m_rp) pick = 0;
      else begin
        for (int i = 0; i < 12; i++)
          if (pick < 0 && m_req[i] && m_en[i] && !m_if) pick = i + 1;
        if (pick < 0 && m_bp) pick = 13;
      end
      acc = irq_ack && m_valid;
      case (reg_addr)
        0: m_rd = m_en;
        1: m_rd = m_req;
        2: m_rd = {8'd0, m_pol};
        default: m_rd = {11'd0, m_if};
      endcase
      if (acc && m_code >= 1 && m_code <= 12) m_req[m_code-1] = 1'b0;
      if (reg_we && reg_addr == 1) m_req = m_req & reg_wdata;
      m_req = m_req | hs;
      if (reg_we && reg_addr == 0) m_en = reg_wdata;
      if (reg_we && reg_addr == 2) m_pol = reg_wdata[3:0];
      if (acc) m_if = 1; else if (reg_we && reg_addr == 3) m_if = reg_wdata[0];
      if (acc && m_code == 0) m_rp = 0;
      if (brk_req) m_bp = 1; else if (acc && m_code == 13) m_bp = 0;
      e_prev = act; e2 = e1; e1 = ext_pin;
      k_prev = kand; k2 = k1; k1 = key_pin;
      m_valid = (pick >= 0) && !acc;
      m_code = (pick < 0) ? 0 : pick;
      m_vec = exp_vec(m_code);
    end
  end

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R3 model irq_valid", irq_valid, m_valid);
      if (m_valid) chk("R3 model irq_code", irq_code, m_code);
      if (m_valid) chk("R4 model irq_vec", irq_vec, m_vec);
      chk("R2 model reg_rdata", reg_rdata, m_rd);
      chk("R5 model iflag", iflag, m_if);
    end
  end

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [11:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [11:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic take(input string tag, input logic [3:0] ec, input logic [15:0] ev);
    int n = 0;
    while (!irq_valid && n < 20) begin @(negedge clk); n++; end
    chk({tag, " valid"}, irq_valid, 1);
    chk({tag, " code"}, irq_code, ec);
    chk({tag, " vector"}, irq_vec, ev);
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
    chk("R5 valid low after accept", irq_valid, 0);
  endtask

  initial begin
    while (cyc < 100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] d;
    wcyc(4);
    rst = 0;
    @(negedge clk);
    chk("R12 iflag after reset", iflag, 1);
    take("R12 reset entry", 4'd0, 16'hFFFC);
    rd(0, d); chk("R12 enables zero", d, 0);
    rd(1, d); chk("R12 requests zero", d, 0);

    wr(1, 12'hFFF);
    rd(1, d); chk("R2 writing 1 does not set request", d, 0);

    timer_uf = 5'b11111; sio_done = 1; adc_done = 1; adc_sel = 0;
    @(negedge clk);
    timer_uf = 0; sio_done = 0; adc_done = 0;
    rd(1, d); chk("R10 A-D ignored without select", d, 12'h33C);
    wcyc(2); chk("R1 no enable no request", irq_valid, 0);
    wr(0, 12'hFFF);
    rd(0, d); chk("R2 enable readback", d, 12'hFFF);
    wcyc(2); chk("R1 disable flag masks", irq_valid, 0);
    wr(3, 0);
    take("R3 timer X", 4'd3, 16'hFFF2);
    rd(3, d); chk("R5 flag set by accept", d, 1);
    rd(1, d); chk("R5 served request cleared", d, 12'h338);
    wr(1, 12'hFF7);
    rd(1, d); chk("R2 software clear", d, 12'h330);
    wr(3, 0); take("R3 timer 1", 4'd5, 16'hFFEE);
    wr(3, 0); take("R3 timer 3", 4'd6, 16'hFFEC);
    wr(3, 0); take("R3 timer 2", 4'd9, 16'hFFE6);
    wr(3, 0); take("R4 serial", 4'd10, 16'hFFE2);

    brk_req = 1; @(negedge clk); brk_req = 0;
    take("R6 break while flag set", 4'd13, 16'hFFDC);

    wr(3, 0);
    adc_sel = 1; adc_done = 1; brk_req = 1;
    @(negedge clk);
    adc_done = 0; brk_req = 0;
    take("R10 A-D over break", 4'd12, 16'hFFDE);
    take("R3 break lowest", 4'd13, 16'hFFDC);

    ext_pin[1] = 1; wcyc(5);
    rd(1, d); chk("R7 rising edge pin B", d, 12'h002);
    chk("R1 masked by flag", irq_valid, 0);
    wr(1, 0);
    wr(2, 12'h002); wcyc(4);
    rd(1, d); chk("R8 flip to inactive no request", d, 0);
    ext_pin[1] = 0; wcyc(5);
    rd(1, d); chk("R7 falling edge pin B", d, 12'h002);
    wr(1, 0);
    wr(2, 12'h003); wcyc(4);
    rd(1, d); chk("R8 polarity flip raises pin A", d, 12'h001);
    rd(2, d); chk("R2 polarity readback", d, 12'h003);
    wr(1, 0);

    reg_we = 1; reg_addr = 1; reg_wdata = 0; timer_uf = 5'b00001;
    @(negedge clk);
    reg_we = 0; timer_uf = 0;
    rd(1, d); chk("R11 hardware set beats clear", d, 12'h004);
    wr(1, 0);

    key_pin[6] = 0; wcyc(5);
    rd(1, d); chk("R9 output-mode key ignored", d, 0);
    key_pin[2] = 0; wcyc(5);
    rd(1, d); chk("R9 key falling", d, 12'h400);
    wr(1, 0);
    key_pin = '1; wcyc(5);
    rd(1, d); chk("R9 key rising no request", d, 0);

    timer_uf = 5'b10000; sio_done = 1;
    @(negedge clk);
    timer_uf = 0; sio_done = 0;
    wr(0, 12'hEFF);
    wr(3, 0);
    take("R1 disabled timer 2 skipped", 4'd10, 16'hFFE2);
    wr(0, 12'hFFF);
    wr(3, 0);
    take("R1 timer 2 after enable", 4'd9, 16'hFFE6);
    wcyc(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule